// File: doc/BRIEF.md
# Password-Locked Test Mode Controller

This block controls entry to the chip's test and external-programming modes with a one-byte secret. A bus master fixes the secret by issuing a write that carries the protection-setting tag and selects the password register. That write disables the test modes. Test access comes back only after a later tagged write whose data equals the stored secret. The password register is write-only, so no read path exposes the secret. The two status flags live in a separate protection-flag register that can be read back.

The lock is a three-state machine:
- `LK_BLANK`: the password has never been written. Test-mode-disable flag = 1, password-OK flag = 1.
- `LK_SEALED`: the secret is fixed. Test-mode-disable flag = 0, password-OK flag = 1.
- `LK_OPEN`: a matching write has been accepted. Test-mode-disable flag = 0, password-OK flag = 0.

The transitions are:
- `t_seal`: `LK_BLANK` to `LK_SEALED` on the first tagged password write. This write captures the data.
- `t_unseal`: `LK_SEALED` to `LK_OPEN` on a tagged password write whose data matches the secret.
- `t_reject`: `LK_SEALED` to `LK_SEALED` on a tagged password write whose data does not match. This raises a mismatch pulse.
- `t_load`: from any state to the state that the preload flags name. This path also loads the secret.

The non-volatile backing is modelled as registers. Reset sets them to the erased value, and a preload input can restore a saved image.

Top module: `pwlock_ctrl`

## Requirements
- R1: After reset, `tmdis_flag`=1, `pwok_flag`=1, `test_en`=1 and `mismatch`=0.
- R2: In `LK_BLANK`, a write with `wr_en`=1, `wr_setprot`=1 and `wr_sel_pw`=1 stores `wr_data` as the secret. From the next cycle, `tmdis_flag`=0, `pwok_flag`=1 and `test_en`=0.
- R3: In `LK_SEALED`, a tagged password write whose data equals the secret makes `pwok_flag`=0 and `test_en`=1 from the next cycle.
- R4: In `LK_SEALED`, a tagged password write with non-matching data leaves both flags and the secret unchanged. It makes `mismatch`=1 for exactly the next cycle.
- R5: The following writes have no effect on the flags, the secret or `mismatch`: a write with `wr_setprot`=0, and a write with `wr_sel_pw`=0.
- R6: With `rd_sel_pw`=1, `rd_data` is all ones. With `rd_sel_pw`=0, `rd_data` carries `tmdis_flag` at bit 1, `pwok_flag` at bit 0, and ones in all other bits.
- R7: `preload_en`=1 loads `preload_pw` as the secret and sets the state from the preload flags for the next cycle:
  - `preload_tmdis`=1 gives `LK_BLANK`.
  - `preload_tmdis`=0 with `preload_pwok`=1 gives `LK_SEALED`.
  - `preload_tmdis`=0 with `preload_pwok`=0 gives `LK_OPEN`.
  A preload takes priority over a write in the same cycle.
- R8: In `LK_OPEN`, tagged password writes change nothing and raise no mismatch.
- R9: Once sealed, the secret can be changed only by preload. A tagged write of a different value, including the erased value, does not replace it.
- R10: `test_en` equals `tmdis_flag` OR NOT `pwok_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| preload_en | input | 1 | Load the non-volatile image this cycle |
| preload_pw | input | PW_W | Secret value from the image |
| preload_tmdis | input | 1 | Test-mode-disable flag from the image |
| preload_pwok | input | 1 | Password-OK flag from the image |
| wr_en | input | 1 | Bus write strobe |
| wr_setprot | input | 1 | Write is tagged as a protection-setting operation |
| wr_sel_pw | input | 1 | Write targets the password register |
| wr_data | input | PW_W | Write data |
| rd_sel_pw | input | 1 | Read selects the password register (1) or the flag register (0) |
| rd_data | output | PW_W | Read data |
| tmdis_flag | output | 1 | Test-mode-disable flag (0 = test disabled by a fixed secret) |
| pwok_flag | output | 1 | Password-OK flag (0 = matching write accepted) |
| test_en | output | 1 | Test and external-programming modes allowed |
| mismatch | output | 1 | One-cycle pulse after a rejected password write |

## Verification
The bench builds the block with its default 8-bit secret and the all-ones erased value. With these values the erased pattern itself can be offered as a wrong password once the lock is sealed. That case shows a sealed lock cannot be reset to the erased value by a write. The 8-bit width also keeps the flag-register layout fully visible in one read byte, so every bit of `rd_data` is checked in both read selections.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;
    typedef enum logic [1:0] {
        LK_BLANK  = 2'd0,
        LK_SEALED = 2'd1,
        LK_OPEN   = 2'd2
    } lk_state_e;
endpackage

// File: rtl/pwlock_store.sv
module pwlock_store #(
    parameter int PW_W = 8,
    parameter logic [PW_W-1:0] ERASED = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            preload_en,
    input  logic [PW_W-1:0] preload_pw,
    input  logic            capture,
    input  logic [PW_W-1:0] wr_data,
    output logic [PW_W-1:0] pw_q,
    output logic            match
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q <= ERASED;
        end else if (preload_en) begin
            pw_q <= preload_pw;
        end else if (capture) begin
            pw_q <= wr_data;
        end
    end

    assign match = (wr_data == pw_q);
endmodule

// File: rtl/pwlock_fsm.sv
module pwlock_fsm
    import pwlock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      preload_en,
    input  logic      preload_tmdis,
    input  logic      preload_pwok,
    input  logic      wr_hit,
    input  logic      match,
    output lk_state_e st,
    output logic      capture,
    output logic      mismatch
);
    lk_state_e st_nxt;
    logic      mis_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= LK_BLANK;
            mismatch <= 1'b0;
        end else begin
            st       <= st_nxt;
            mismatch <= mis_d;
        end
    end

    // next-state: t_load, t_seal, t_unseal, t_reject
    always_comb begin
        st_nxt = st;
        if (preload_en) begin
            if (preload_tmdis)     st_nxt = LK_BLANK;
            else if (preload_pwok) st_nxt = LK_SEALED;
            else                   st_nxt = LK_OPEN;
        end else if (wr_hit) begin
            unique case (st)
                LK_BLANK:  st_nxt = LK_SEALED;
                LK_SEALED: st_nxt = match ? LK_OPEN : LK_SEALED;
                LK_OPEN:   st_nxt = LK_OPEN;
                default:   st_nxt = LK_BLANK;
            endcase
        end
    end

    // outputs: capture strobe and mismatch request
    always_comb begin
        capture = 1'b0;
        mis_d   = 1'b0;
        if (!preload_en && wr_hit) begin
            unique case (st)
                LK_BLANK:  capture = 1'b1;
                LK_SEALED: mis_d   = !match;
                LK_OPEN:   ;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/pwlock_ctrl.sv
module pwlock_ctrl
    import pwlock_pkg::*;
#(
    parameter int PW_W = 8,
    parameter logic [PW_W-1:0] ERASED = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            preload_en,
    input  logic [PW_W-1:0] preload_pw,
    input  logic            preload_tmdis,
    input  logic            preload_pwok,
    input  logic            wr_en,
    input  logic            wr_setprot,
    input  logic            wr_sel_pw,
    input  logic [PW_W-1:0] wr_data,
    input  logic            rd_sel_pw,
    output logic [PW_W-1:0] rd_data,
    output logic            tmdis_flag,
    output logic            pwok_flag,
    output logic            test_en,
    output logic            mismatch
);
    localparam int FLAG_PAD = PW_W - 2;

    lk_state_e       st;
    logic            wr_hit;
    logic            capture;
    logic            match;
    logic [PW_W-1:0] pw_q;

    assign wr_hit = wr_en && wr_setprot && wr_sel_pw;

    pwlock_store #(.PW_W(PW_W), .ERASED(ERASED)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .preload_en (preload_en),
        .preload_pw (preload_pw),
        .capture    (capture),
        .wr_data    (wr_data),
        .pw_q       (pw_q),
        .match      (match)
    );

    pwlock_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .preload_en    (preload_en),
        .preload_tmdis (preload_tmdis),
        .preload_pwok  (preload_pwok),
        .wr_hit        (wr_hit),
        .match         (match),
        .st            (st),
        .capture       (capture),
        .mismatch      (mismatch)
    );

    assign tmdis_flag = (st == LK_BLANK);
    assign pwok_flag  = (st != LK_OPEN);
    assign test_en    = tmdis_flag || !pwok_flag;
    assign rd_data    = rd_sel_pw ? {PW_W{1'b1}}
                                  : {{FLAG_PAD{1'b1}}, tmdis_flag, pwok_flag};

    // R9: a sealed secret moves only through preload
    p_pw_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != LK_BLANK && !preload_en) |=> $stable(pw_q));

    // R3: opening needs a matching tagged write
    p_open_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_SEALED && !preload_en && !(wr_hit && match)) |=> st != LK_OPEN);

    // R4: mismatch only follows a rejected write and the lock stays sealed
    p_mismatch_sealed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_SEALED && !preload_en && wr_hit && !match) |=> (mismatch && st == LK_SEALED));

    // R8: an open lock ignores writes
    p_open_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_OPEN && !preload_en) |=> (st == LK_OPEN && !mismatch));

    // R7: preload wins over any write
    p_preload_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && preload_tmdis) |=> (tmdis_flag && pwok_flag && pw_q == $past(preload_pw)));

    // R6: password read never exposes the secret
    p_pw_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_pw |-> (rd_data == {PW_W{1'b1}}));
endmodule

// File: tb/pwlock_ctrl_tb_top.sv
module pwlock_ctrl_tb_top;
    localparam int PW_W = 8;
    localparam int NV   = 11;
    // {tag, sel, data, exp_tmdis, exp_pwok, exp_mis}
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'hA5, 3'b110},  // R5 untagged
        {1'b1, 1'b0, 8'hA5, 3'b110},  // R5 other register
        {1'b1, 1'b1, 8'h3C, 3'b010},  // R2 seal
        {1'b1, 1'b1, 8'h3D, 3'b011},  // R4 mismatch
        {1'b1, 1'b1, 8'hC3, 3'b011},  // R4 back-to-back
        {1'b0, 1'b1, 8'h3C, 3'b010},  // R5 untagged match
        {1'b1, 1'b0, 8'h3C, 3'b010},  // R5 other register match
        {1'b1, 1'b1, 8'hFF, 3'b011},  // R9 erased value refused
        {1'b1, 1'b1, 8'h3C, 3'b000},  // R3 unseal
        {1'b1, 1'b1, 8'h00, 3'b000},  // R8
        {1'b1, 1'b1, 8'h3C, 3'b000}   // R8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic preload_en = 1'b0, preload_tmdis = 1'b0, preload_pwok = 1'b0;
    logic [PW_W-1:0] preload_pw = '0;
    logic wr_en = 1'b0, wr_setprot = 1'b0, wr_sel_pw = 1'b0;
    logic [PW_W-1:0] wr_data = '0;
    logic rd_sel_pw = 1'b0;
    logic [PW_W-1:0] rd_data;
    logic tmdis_flag, pwok_flag, test_en, mismatch;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwlock_ctrl #(.PW_W(PW_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .preload_en(preload_en), .preload_pw(preload_pw),
        .preload_tmdis(preload_tmdis), .preload_pwok(preload_pwok),
        .wr_en(wr_en), .wr_setprot(wr_setprot), .wr_sel_pw(wr_sel_pw),
        .wr_data(wr_data), .rd_sel_pw(rd_sel_pw), .rd_data(rd_data),
        .tmdis_flag(tmdis_flag), .pwok_flag(pwok_flag),
        .test_en(test_en), .mismatch(mismatch)
    );

    task automatic check(string req, logic [PW_W-1:0] act, logic [PW_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic flags(string req, logic tm, logic ok, logic mis);
        check({req, " tmdis"}, {7'd0, tmdis_flag}, {7'd0, tm});
        check({req, " pwok"}, {7'd0, pwok_flag}, {7'd0, ok});
        check({req, " mismatch"}, {7'd0, mismatch}, {7'd0, mis});
        check("R10 test_en", {7'd0, test_en}, {7'd0, tm | ~ok});
        rd_sel_pw = 1'b0; #1;
        check("R6 flag read", rd_data, {6'h3F, tm, ok});
        rd_sel_pw = 1'b1; #1;
        check("R6 pw read", rd_data, 8'hFF);
    endtask

    // drive at negedge, sample at next negedge
    task automatic wr(logic tag, logic sel, logic [PW_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_setprot = tag; wr_sel_pw = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_setprot = 1'b0; wr_sel_pw = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        flags("R1 reset", 1'b1, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][12], VEC[i][11], VEC[i][10:3]);
            flags($sformatf("vec%0d R2/R3/R4/R5/R8/R9", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R4: mismatch is a single-cycle pulse
        wr(1'b0, 1'b0, 8'h00);
        do_reset();
        wr(1'b1, 1'b1, 8'h11);
        wr(1'b1, 1'b1, 8'h12);
        flags("R4 pulse", 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        flags("R4 pulse end", 1'b0, 1'b1, 1'b0);

        // R7: preload wins over simultaneous write, loads sealed image
        @(negedge clk);
        preload_en = 1'b1; preload_pw = 8'h5A; preload_tmdis = 1'b0; preload_pwok = 1'b1;
        wr_en = 1'b1; wr_setprot = 1'b1; wr_sel_pw = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        preload_en = 1'b0; wr_en = 1'b0;
        flags("R7 preload sealed", 1'b0, 1'b1, 1'b0);
        wr(1'b1, 1'b1, 8'h11);
        flags("R7 old secret replaced", 1'b0, 1'b1, 1'b1);
        wr(1'b1, 1'b1, 8'h5A);
        flags("R7 preloaded secret opens", 1'b0, 1'b0, 1'b0);

        // R7: preload blank image, then R2 works again
        @(negedge clk);
        preload_en = 1'b1; preload_pw = 8'hFF; preload_tmdis = 1'b1; preload_pwok = 1'b1;
        @(negedge clk);
        preload_en = 1'b0;
        flags("R7 preload blank", 1'b1, 1'b1, 1'b0);
        wr(1'b1, 1'b1, 8'h77);
        flags("R2 reseal", 1'b0, 1'b1, 1'b0);

        // R7: preload open image
        @(negedge clk);
        preload_en = 1'b1; preload_pw = 8'h77; preload_tmdis = 1'b0; preload_pwok = 1'b0;
        @(negedge clk);
        preload_en = 1'b0;
        flags("R7 preload open", 1'b0, 1'b0, 1'b0);

        do_reset();
        flags("R1 second reset", 1'b1, 1'b1, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule